// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block arbitrates among 256 numbered interrupt vectors for one processor. It keeps three 256-bit maps: one of vectors waiting for service, one of vectors the processor is handling now, and one that records whether each waiting vector was raised as a level or an edge. A source raises a request by presenting a vector number and a level flag. The block compares the best waiting vector with the best vector in service and with a programmable priority threshold. From this it decides whether to raise the processor's interrupt line.

When the processor takes an interrupt it pulses an acknowledge. The block then moves the winning vector from the waiting map to the in-service map and returns its number one cycle later. When the handler finishes, the processor pulses end-of-interrupt. The block then retires the highest vector in service. If that vector was level-triggered, it also sends a notification outward so the originating source can re-arm. Software can read each map back as eight 32-bit words through a combinational read port, and it can read the threshold register the same way.

Top module: `irq_prio_top`

## Requirements
- R1: Each map reads back as eight 32-bit words, with vector v at word v>>5, bit v&31. In-service word i is at offset 0x100+0x10*i, trigger-mode word i at 0x180+0x10*i, and pending word i at 0x200+0x10*i. The threshold register reads at offset 0x080 in bits 7:0. Any other offset reads zero.
- R2: A request for a vector whose pending bit is already set changes neither the pending map nor the trigger-mode map.
- R3: An accepted request sets the vector's pending bit. It sets the vector's trigger-mode bit when the level flag is 1 and clears it when the flag is 0.
- R4: Requests for vectors 0 to 15 or for vector 255 are ignored and change no map.
- R5: The interrupt output is high exactly when some vector is pending, the highest pending vector is numerically above the highest in-service vector (or nothing is in service), and bits 7:4 of the highest pending vector exceed bits 7:4 of the threshold register.
- R6: An acknowledge while the interrupt output is high clears the highest pending bit and sets the matching in-service bit. In the next cycle it pulses the acknowledge-done output for one cycle with that vector on the acknowledge vector output.
- R7: An acknowledge while the interrupt output is low leaves acknowledge-done low and changes no map.
- R8: An end-of-interrupt clears the highest set in-service bit. If that vector's trigger-mode bit is 1, the remote notification output pulses for one cycle in the next cycle and carries the vector. If the bit is 0, there is no pulse.
- R9: An end-of-interrupt while no in-service bit is set changes no map and produces no remote notification.
- R10: A threshold write stores only bits 7:0 of the written word.
- R11: After reset every map and the threshold register are zero, and the interrupt, acknowledge-done and remote notification outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe |
| reqVector | input | 8 | Requested vector number |
| reqLevel | input | 1 | 1 = level-triggered request, 0 = edge |
| intrOut | output | 1 | Interrupt line to the processor |
| intAck | input | 1 | Acknowledge strobe from the processor |
| ackDone | output | 1 | One-cycle pulse: a vector was handed over |
| ackVector | output | 8 | Vector handed over on the last acknowledge |
| eoiStrobe | input | 1 | End-of-interrupt strobe |
| remoteEoiValid | output | 1 | One-cycle remote notification pulse |
| remoteEoiVector | output | 8 | Vector carried by the remote notification |
| tprWrite | input | 1 | Threshold register write strobe |
| tprData | input | 32 | Threshold write data |
| rdAddr | input | 12 | Readback byte offset |
| rdData | output | 32 | Readback word |

## Verification
Requests for every vector from 0 to 255 are issued, with the level flag taken from the vector's low bit. The full readback of all three maps then shows that the invalid vectors were dropped, that each valid vector reached the right word and bit, and that the trigger mode follows the flag. The maps are then drained one vector at a time by an acknowledge and end-of-interrupt pair, from 254 down to 16. This checks the descending order of hand-over, shows that the interrupt stays low while a higher vector is in service, and shows that remote notifications alternate with the trigger mode. A last pattern places two vectors on either side of a priority class boundary against a threshold of the same class. It separates the strict class comparison from a less-or-equal one, and it covers acknowledge with a closed gate and end-of-interrupt with nothing in service.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  // Vector numbering width; the block tracks 2**VEC_BITS vectors.
  localparam int unsigned VEC_BITS = 8;
  localparam int unsigned NUM_VEC  = 1 << VEC_BITS;
  // The priority class is the upper nibble of a vector.
  localparam int unsigned CLS_LSB  = VEC_BITS - 4;

  typedef logic [VEC_BITS-1:0] vec_t;

  // Strobes from the control to the bitmap datapath.
  typedef struct packed {
    logic setIrr;
    vec_t reqVec;
    logic reqLevel;
    logic clrIrr;
    logic setIsr;
    vec_t ackVec;
    logic clrIsr;
    vec_t eoiVec;
    logic tprWe;
    vec_t tprVal;
  } ctrlStrobe_t;
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned WIDTH = 256,
  localparam int unsigned IDX_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] bits,
  output logic             found,
  output logic [IDX_W-1:0] index
);
  // Highest set bit wins: later loop iterations override earlier ones.
  always_comb begin
    found = 1'b0;
    index = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (bits[i]) begin
        found = 1'b1;
        index = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_prio_datapath.sv
module irq_prio_datapath
  import irq_prio_pkg::*;
#(
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned MIN_VEC = 16,
  localparam int unsigned NUM_WORDS = NUM_VEC / WORD_W,
  localparam int unsigned GRP_W     = ADDR_W - 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  vec_t              lookVec,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [WORD_W-1:0] rdData,
  output logic              hiIrrValid,
  output vec_t              hiIrr,
  output logic              hiIsrValid,
  output vec_t              hiIsr,
  output logic              reqPending,
  output logic              eoiTrig,
  output vec_t              tprCur
);
  // Readback groups, in units of 16-byte slots.
  localparam int unsigned TPR_GRP = 8;
  localparam int unsigned ISR_GRP = 16;
  localparam int unsigned TMR_GRP = ISR_GRP + NUM_WORDS;
  localparam int unsigned IRR_GRP = TMR_GRP + NUM_WORDS;

  logic [NUM_VEC-1:0] irr, isr, tmr;
  vec_t               tpr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irr <= '0;
      isr <= '0;
      tmr <= '0;
      tpr <= '0;
    end else begin
      if (strobe.setIrr) begin
        irr[strobe.reqVec] <= 1'b1;
        tmr[strobe.reqVec] <= strobe.reqLevel;
      end
      if (strobe.clrIrr) irr[strobe.ackVec] <= 1'b0;
      if (strobe.setIsr) isr[strobe.ackVec] <= 1'b1;
      if (strobe.clrIsr) isr[strobe.eoiVec] <= 1'b0;
      if (strobe.tprWe)  tpr <= strobe.tprVal;
    end
  end

  irq_prio_enc #(.WIDTH(NUM_VEC)) irrEnc_i (.bits(irr), .found(hiIrrValid), .index(hiIrr));
  irq_prio_enc #(.WIDTH(NUM_VEC)) isrEnc_i (.bits(isr), .found(hiIsrValid), .index(hiIsr));

  assign reqPending = irr[lookVec];
  assign eoiTrig    = tmr[hiIsr];
  assign tprCur     = tpr;

  logic [WORD_W-1:0] isrWord [NUM_WORDS];
  logic [WORD_W-1:0] tmrWord [NUM_WORDS];
  logic [WORD_W-1:0] irrWord [NUM_WORDS];

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_words
    assign isrWord[w] = isr[w*WORD_W +: WORD_W];
    assign tmrWord[w] = tmr[w*WORD_W +: WORD_W];
    assign irrWord[w] = irr[w*WORD_W +: WORD_W];
  end

  logic [GRP_W-1:0] grp;
  assign grp = rdAddr[ADDR_W-1:4];

  always_comb begin
    rdData = '0;
    if (rdAddr[3:0] == 4'h0) begin
      if (grp == GRP_W'(TPR_GRP)) rdData = WORD_W'(tpr);
      for (int w = 0; w < NUM_WORDS; w++) begin
        if (grp == GRP_W'(ISR_GRP + w)) rdData = isrWord[w];
        if (grp == GRP_W'(TMR_GRP + w)) rdData = tmrWord[w];
        if (grp == GRP_W'(IRR_GRP + w)) rdData = irrWord[w];
      end
    end
  end

  // R2: control never asks to set a bit that is already pending
  p_dup_drop_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setIrr |-> !irr[strobe.reqVec]);

  // R3: accepted request lands in the pending and trigger maps
  p_req_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setIrr |=> irr[$past(strobe.reqVec)] && (tmr[$past(strobe.reqVec)] == $past(strobe.reqLevel)));

  // R4: only valid vectors reach the maps
  p_invalid_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setIrr |-> (strobe.reqVec >= vec_t'(MIN_VEC)) && (strobe.reqVec != '1));

  // R6: acknowledged vector moves from pending to in-service
  p_ack_move_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setIsr |=> isr[$past(strobe.ackVec)] && !irr[$past(strobe.ackVec)]);

  // R8: end-of-interrupt retires its vector
  p_eoi_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrIsr |=> !isr[$past(strobe.eoiVec)]);
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned MIN_VEC = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  vec_t              reqVector,
  input  logic              reqLevel,
  input  logic              intAck,
  input  logic              eoiStrobe,
  input  logic              tprWrite,
  input  logic [WORD_W-1:0] tprData,
  input  logic              hiIrrValid,
  input  vec_t              hiIrr,
  input  logic              hiIsrValid,
  input  vec_t              hiIsr,
  input  logic              reqPending,
  input  logic              eoiTrig,
  input  vec_t              tprCur,
  output ctrlStrobe_t       strobe,
  output logic              intrOut,
  output logic              ackDone,
  output vec_t              ackVector,
  output logic              remoteEoiValid,
  output vec_t              remoteEoiVector
);
  logic reqVecOk;
  logic aboveIsr;
  logic aboveTpr;
  logic gateOpen;

  assign reqVecOk = (reqVector >= vec_t'(MIN_VEC)) && (reqVector != '1);
  assign aboveIsr = !hiIsrValid || (hiIrr > hiIsr);
  assign aboveTpr = hiIrr[VEC_BITS-1:CLS_LSB] > tprCur[VEC_BITS-1:CLS_LSB];
  assign gateOpen = hiIrrValid && aboveIsr && aboveTpr;
  assign intrOut  = gateOpen;

  always_comb begin
    strobe          = '0;
    strobe.reqVec   = reqVector;
    strobe.reqLevel = reqLevel;
    strobe.setIrr   = reqValid && reqVecOk && !reqPending;
    strobe.ackVec   = hiIrr;
    strobe.clrIrr   = intAck && gateOpen;
    strobe.setIsr   = intAck && gateOpen;
    strobe.eoiVec   = hiIsr;
    strobe.clrIsr   = eoiStrobe && hiIsrValid;
    strobe.tprWe    = tprWrite;
    strobe.tprVal   = tprData[VEC_BITS-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackDone         <= 1'b0;
      ackVector       <= '0;
      remoteEoiValid  <= 1'b0;
      remoteEoiVector <= '0;
    end else begin
      ackDone        <= strobe.setIsr;
      remoteEoiValid <= strobe.clrIsr && eoiTrig;
      if (strobe.setIsr) ackVector <= hiIrr;
      if (strobe.clrIsr && eoiTrig) remoteEoiVector <= hiIsr;
    end
  end

  // R7: closed gate means no hand-over
  p_ack_closed_r7: assert property (@(posedge clk) disable iff (!rstN)
    intAck && !intrOut |=> !ackDone);

  // R5: a handed-over vector beat the threshold class at the time
  p_ack_class_r5: assert property (@(posedge clk) disable iff (!rstN)
    ackDone |-> ackVector[VEC_BITS-1:CLS_LSB] > $past(tprCur[VEC_BITS-1:CLS_LSB]));

  // R9: nothing in service, nothing notified
  p_eoi_empty_r9: assert property (@(posedge clk) disable iff (!rstN)
    eoiStrobe && !hiIsrValid |=> !remoteEoiValid);

  // R8: remote notification only follows an end-of-interrupt
  p_remote_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    remoteEoiValid |-> $past(eoiStrobe));
endmodule

// File: rtl/irq_prio_top.sv
module irq_prio_top
  import irq_prio_pkg::*;
#(
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned MIN_VEC = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [7:0]        reqVector,
  input  logic              reqLevel,
  output logic              intrOut,
  input  logic              intAck,
  output logic              ackDone,
  output logic [7:0]        ackVector,
  input  logic              eoiStrobe,
  output logic              remoteEoiValid,
  output logic [7:0]        remoteEoiVector,
  input  logic              tprWrite,
  input  logic [WORD_W-1:0] tprData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [WORD_W-1:0] rdData
);
  ctrlStrobe_t strobe;
  logic        hiIrrValid, hiIsrValid, reqPending, eoiTrig;
  vec_t        hiIrr, hiIsr, tprCur;

  irq_prio_ctrl #(.WORD_W(WORD_W), .MIN_VEC(MIN_VEC)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqVector(reqVector), .reqLevel(reqLevel),
    .intAck(intAck), .eoiStrobe(eoiStrobe),
    .tprWrite(tprWrite), .tprData(tprData),
    .hiIrrValid(hiIrrValid), .hiIrr(hiIrr),
    .hiIsrValid(hiIsrValid), .hiIsr(hiIsr),
    .reqPending(reqPending), .eoiTrig(eoiTrig), .tprCur(tprCur),
    .strobe(strobe), .intrOut(intrOut),
    .ackDone(ackDone), .ackVector(ackVector),
    .remoteEoiValid(remoteEoiValid), .remoteEoiVector(remoteEoiVector)
  );

  irq_prio_datapath #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .MIN_VEC(MIN_VEC)) dp_i (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .lookVec(reqVector),
    .rdAddr(rdAddr), .rdData(rdData),
    .hiIrrValid(hiIrrValid), .hiIrr(hiIrr),
    .hiIsrValid(hiIsrValid), .hiIsr(hiIsr),
    .reqPending(reqPending), .eoiTrig(eoiTrig), .tprCur(tprCur)
  );

  // R11: outputs quiet coming out of reset
  p_reset_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !ackDone && !remoteEoiValid);
endmodule

// File: tb/irq_prio_top_tb_top.sv
module irq_prio_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [7:0]  reqVector = '0;
  logic        reqLevel = 1'b0;
  logic        intrOut;
  logic        intAck = 1'b0;
  logic        ackDone;
  logic [7:0]  ackVector;
  logic        eoiStrobe = 1'b0;
  logic        remoteEoiValid;
  logic [7:0]  remoteEoiVector;
  logic        tprWrite = 1'b0;
  logic [31:0] tprData = '0;
  logic [11:0] rdAddr = '0;
  logic [31:0] rdData;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  irq_prio_top dut_i (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqVector(reqVector), .reqLevel(reqLevel),
    .intrOut(intrOut), .intAck(intAck), .ackDone(ackDone), .ackVector(ackVector),
    .eoiStrobe(eoiStrobe), .remoteEoiValid(remoteEoiValid), .remoteEoiVector(remoteEoiVector),
    .tprWrite(tprWrite), .tprData(tprData), .rdAddr(rdAddr), .rdData(rdData)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic readWord(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    rdAddr = a;
    #1 d = rdData;
  endtask

  task automatic request(input logic [7:0] v, input logic lvl);
    @(negedge clk);
    reqValid = 1'b1; reqVector = v; reqLevel = lvl;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk);
    intAck = 1'b1;
    @(negedge clk);
    intAck = 1'b0;
  endtask

  task automatic eoi();
    @(negedge clk);
    eoiStrobe = 1'b1;
    @(negedge clk);
    eoiStrobe = 1'b0;
  endtask

  task automatic setTpr(input logic [31:0] d);
    @(negedge clk);
    tprWrite = 1'b1; tprData = d;
    @(negedge clk);
    tprWrite = 1'b0;
  endtask

  // Expected maps after the full request sweep
  function automatic logic [31:0] sweepIrr(input int w);
    logic [31:0] r = '0;
    for (int b = 0; b < 32; b++) begin
      int v = w * 32 + b;
      r[b] = (v >= 16) && (v <= 254);
    end
    return r;
  endfunction

  function automatic logic [31:0] sweepTmr(input int w);
    logic [31:0] r = '0;
    for (int b = 0; b < 32; b++) begin
      int v = w * 32 + b;
      r[b] = (v >= 16) && (v <= 254) && (v % 2 == 1);
    end
    return r;
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin : stimulus
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R11 and R1: everything reads zero after reset
    for (int w = 0; w < 8; w++) begin
      readWord(12'h100 + 12'(w * 16), d); check("R11 isr", d, 0);
      readWord(12'h180 + 12'(w * 16), d); check("R11 tmr", d, 0);
      readWord(12'h200 + 12'(w * 16), d); check("R11 irr", d, 0);
    end
    readWord(12'h080, d); check("R11 tpr", d, 0);
    check("R11 intr", {31'b0, intrOut}, 0);
    check("R11 ackDone", {31'b0, ackDone}, 0);
    check("R11 remote", {31'b0, remoteEoiValid}, 0);

    // R4: invalid vectors leave every map empty
    for (int v = 0; v < 16; v++) request(8'(v), 1'b1);
    request(8'd255, 1'b1);
    for (int w = 0; w < 8; w++) begin
      readWord(12'h200 + 12'(w * 16), d); check("R4 irr", d, 0);
      readWord(12'h180 + 12'(w * 16), d); check("R4 tmr", d, 0);
    end
    check("R4 intr", {31'b0, intrOut}, 0);

    // R3, R4 and R1: sweep of every vector, level flag = low bit
    for (int v = 0; v < 256; v++) request(8'(v), v[0]);
    for (int w = 0; w < 8; w++) begin
      readWord(12'h200 + 12'(w * 16), d); check("R3 irr word", d, sweepIrr(w));
      readWord(12'h180 + 12'(w * 16), d); check("R3 tmr word", d, sweepTmr(w));
      readWord(12'h100 + 12'(w * 16), d); check("R1 isr word", d, 0);
    end
    readWord(12'h104, d); check("R1 unaligned", d, 0);
    readWord(12'h300, d); check("R1 unmapped", d, 0);

    // R2: re-request of pending even vector with level flag set
    request(8'd20, 1'b1);
    readWord(12'h180, d); check("R2 tmr word0", d, sweepTmr(0));
    readWord(12'h200, d); check("R2 irr word0", d, sweepIrr(0));

    // R10: only the low byte of the threshold write is kept
    setTpr(32'hABCD_12F3);
    readWord(12'h080, d); check("R10 tpr", d, 32'h0000_00F3);

    // R5 and R7: class F does not beat threshold class F
    check("R5 class equal", {31'b0, intrOut}, 0);
    ack();
    check("R7 ackDone", {31'b0, ackDone}, 0);
    readWord(12'h270, d); check("R7 irr word7", d, sweepIrr(7));
    readWord(12'h170, d); check("R7 isr word7", d, 0);

    setTpr(32'h0000_00E0);
    check("R5 class above", {31'b0, intrOut}, 1);
    setTpr(32'h0);

    // R5, R6, R8: drain from highest to lowest
    for (int v = 254; v >= 16; v--) begin
      check("R5 open", {31'b0, intrOut}, 1);
      ack();
      check("R6 ackDone", {31'b0, ackDone}, 1);
      check("R6 ackVector", {24'b0, ackVector}, 32'(v));
      if (v == 254) begin
        readWord(12'h170, d); check("R6 isr word7", d, 32'h4000_0000);
        readWord(12'h270, d); check("R6 irr word7", d, 32'h3FFF_FFFF);
      end
      check("R5 blocked by isr", {31'b0, intrOut}, 0);
      eoi();
      check("R8 remote valid", {31'b0, remoteEoiValid}, 32'(v % 2));
      if (v % 2 == 1) check("R8 remote vector", {24'b0, remoteEoiVector}, 32'(v));
    end
    for (int w = 0; w < 8; w++) begin
      readWord(12'h200 + 12'(w * 16), d); check("R6 irr drained", d, 0);
      readWord(12'h100 + 12'(w * 16), d); check("R8 isr drained", d, 0);
    end

    // R5 class boundary against threshold 0x85
    setTpr(32'h85);
    request(8'h85, 1'b0);
    request(8'h90, 1'b1);
    check("R5 class 9 over 8", {31'b0, intrOut}, 1);
    ack();
    check("R6 ack 0x90", {24'b0, ackVector}, 32'h90);
    check("R5 isr blocks", {31'b0, intrOut}, 0);
    eoi();
    check("R8 remote 0x90", {23'b0, remoteEoiValid, remoteEoiVector}, 32'h190);
    check("R5 class 8 not over 8", {31'b0, intrOut}, 0);
    ack();
    check("R7 closed ack", {31'b0, ackDone}, 0);
    // R9: nothing in service
    eoi();
    check("R9 no remote", {31'b0, remoteEoiValid}, 0);
    readWord(12'h240, d); check("R9 irr word4", d, 32'h0000_0020);
    readWord(12'h140, d); check("R9 isr word4", d, 0);
    setTpr(32'h7F);
    check("R5 class 8 over 7", {31'b0, intrOut}, 1);
    ack();
    check("R6 ack 0x85", {24'b0, ackVector}, 32'h85);
    eoi();
    check("R8 edge no remote", {31'b0, remoteEoiValid}, 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule